// File: doc/BRIEF.md
# Escaped Byte to Comma Symbol Decoder

This block turns a stream of 8-bit bytes into a stream of 9-bit symbols. In each output symbol, bit 8 tells control symbols ("commas") apart from ordinary data. Most bytes pass straight through with bit 8 clear. One reserved byte value, the escape byte, is never forwarded. It is absorbed, and the byte that follows it is read as an escape-data byte. That byte carries a 3-bit code together with protection bits. The code is then turned into either a comma or the literal byte that the escape pair stood for.

The upstream side offers bytes with an enable and is held off with busy. The downstream side presents symbols with valid and may stall them with hold. An escape-data byte that fails its format checks produces no symbol. Instead it raises a one-cycle error pulse, and decoding carries on as if no escape had been seen.

Top module: `esc_comma_decoder`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid`, `err_pulse` and `in_busy` are low.
- R2: An accepted byte other than 8'h1B, when no escape is pending, appears as `{1'b0, byte}` on `out_sym` with `out_valid` high in the cycle after acceptance.
- R3: An accepted 8'h1B, when no escape is pending, produces no symbol and makes the next accepted byte an escape-data byte.
- R4: An escape-data byte for code c (3 bits) is laid out as bits 7:6 = 2'b01, bits 5:3 = ~c, bits 2:0 = c. Any other prefix, or a bits 5:3 field that is not the complement of bits 2:0, is malformed.
- R5: Codes 4, 5, 6 and 7 (start-of-packet, end-of-packet, negative-acknowledge, attention) produce the comma 9'h104, 9'h105, 9'h106 and 9'h107 respectively, that is bit 8 set, bits 7:3 zero and bits 2:0 equal to the code.
- R6: Codes 0, 1, 2 and 3 produce the literal bytes 8'h11 (xon), 8'h13 (xoff), 8'h00 (fill) and 8'h1B (escape) with bit 8 clear.
- R7: A malformed escape-data byte produces no symbol. It raises `err_pulse` for exactly one cycle, in the cycle after acceptance, and the next accepted byte is decoded as a plain byte.
- R8: An 8'h1B accepted while an escape is pending is treated as a malformed escape-data byte.
- R9: A symbol moves downstream only in a cycle with `out_valid` high and `out_hold` low. While a symbol is held, `out_sym` stays stable and `in_busy` is high, so no symbol is dropped or duplicated.
- R10: A byte is consumed only when `in_en` is high and `in_busy` is low. Bytes presented with `in_en` low or while busy leave the output stream and the decoding state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Incoming byte |
| in_en | input | 1 | Incoming byte is offered |
| in_busy | output | 1 | Decoder cannot take a byte this cycle |
| out_sym | output | 9 | Output symbol, bit 8 marks a comma |
| out_valid | output | 1 | `out_sym` holds a symbol |
| out_hold | input | 1 | Downstream stalls the current symbol |
| err_pulse | output | 1 | One-cycle flag for a malformed escape-data byte |

## Verification
The bench walks all eight escape codes. A design with a swapped map entry would emit the wrong comma or literal, and one that fails to clear bit 8 would turn the restored escape byte into a comma. Malformed pairs are sent with a bad prefix, with a bad complement field and as a doubled escape byte, each followed by a plain byte. A decoder that stays in the escaped state would corrupt that following byte, and one that forwards bad bytes would push a stray symbol into the scoreboard. Hold is toggled under traffic, and bytes are presented while busy or with enable low. A design that consumes them would drop, duplicate or misdecode symbols.

// File: rtl/esc_dec_pkg.sv
package esc_dec_pkg;

   localparam int unsigned DEF_BYTE_W   = 8;
   localparam int unsigned DEF_CODE_W   = 3;
   localparam int unsigned DEF_PREFIX   = 1;
   localparam logic [7:0]  DEF_ESC_BYTE = 8'h1B;
   // literal bytes restored for codes 0..3, code 0 in the low byte
   localparam logic [31:0] DEF_LIT_BYTES = {8'h1B, 8'h00, 8'h13, 8'h11};

   typedef enum logic {
      DS_PLAIN     = 1'b0,
      DS_AFTER_ESC = 1'b1
   } dec_state_e;

endpackage

// File: rtl/esc_field_check.sv
module esc_field_check #(
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned PREFIX_VAL = 1
) (
   input  logic [BYTE_W-1:0] data_i,
   output logic [CODE_W-1:0] code_o,
   output logic              ok_o
);
   localparam int unsigned PREFIX_W = BYTE_W - 2*CODE_W;

   logic [PREFIX_W-1:0] prefix_f;
   logic [CODE_W-1:0]   inv_f;
   logic                prefix_ok;
   logic                inv_ok;

   assign prefix_f  = data_i[BYTE_W-1 -: PREFIX_W];
   assign inv_f     = data_i[2*CODE_W-1 : CODE_W];
   assign code_o    = data_i[CODE_W-1:0];
   assign prefix_ok = (prefix_f == PREFIX_W'(PREFIX_VAL));
   assign inv_ok    = (inv_f == ~code_o);
   assign ok_o      = prefix_ok & inv_ok;

endmodule

// File: rtl/esc_code_map.sv
module esc_code_map #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CODE_W = 3,
   parameter int unsigned NLIT   = 4,
   parameter logic [NLIT*BYTE_W-1:0] LIT_BYTES = '0
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [BYTE_W:0]   sym_o
);
   localparam int unsigned NCODE = 1 << CODE_W;

   logic [BYTE_W:0] tbl [NCODE];

   for (genvar c = 0; c < NCODE; c++) begin : g_code
      if (c < NLIT) begin : g_lit
         assign tbl[c] = {1'b0, LIT_BYTES[c*BYTE_W +: BYTE_W]};
      end else begin : g_comma
         assign tbl[c] = {1'b1, {(BYTE_W-CODE_W){1'b0}}, CODE_W'(c)};
      end
   end

   assign sym_o = tbl[code_i];

endmodule

// File: rtl/esc_out_stage.sv
module esc_out_stage #(
   parameter int unsigned SYM_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [SYM_W-1:0] sym_i,
   input  logic             hold_i,
   output logic             valid_o,
   output logic [SYM_W-1:0] sym_o,
   output logic             stall_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         sym_o   <= '0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         sym_o   <= sym_i;
      end else if (valid_o && !hold_i) begin
         valid_o <= 1'b0;
      end
   end

   assign stall_o = valid_o & hold_i;

endmodule

// File: rtl/esc_comma_decoder.sv
module esc_comma_decoder
   import esc_dec_pkg::*;
#(
   parameter int unsigned BYTE_W     = DEF_BYTE_W,
   parameter int unsigned CODE_W     = DEF_CODE_W,
   parameter int unsigned PREFIX_VAL = DEF_PREFIX,
   parameter logic [7:0]  ESC_BYTE   = DEF_ESC_BYTE,
   parameter logic [31:0] LIT_BYTES  = DEF_LIT_BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    in_byte,
   input  logic          in_en,
   output logic          in_busy,
   output logic [8:0]    out_sym,
   output logic          out_valid,
   input  logic          out_hold,
   output logic          err_pulse
);
   localparam int unsigned SYM_W = BYTE_W + 1;
   localparam int unsigned NLIT  = 1 << (CODE_W - 1);

   if (BYTE_W != 8) begin : g_bad_byte_w
      $error("esc_comma_decoder: BYTE_W must be 8");
   end
   if (BYTE_W < 2*CODE_W + 1) begin : g_bad_code_w
      $error("esc_comma_decoder: no room for prefix");
   end
   if (NLIT*BYTE_W != 32) begin : g_bad_lit
      $error("esc_comma_decoder: literal table width mismatch");
   end

   dec_state_e       state_q, state_n;
   logic             accept;
   logic             stall;
   logic             load;
   logic [SYM_W-1:0] sym_n;
   logic             bad_n;
   logic [CODE_W-1:0] code;
   logic             fmt_ok;
   logic [SYM_W-1:0] map_sym;
   logic             esc_pending;

   esc_field_check #(
      .BYTE_W(BYTE_W), .CODE_W(CODE_W), .PREFIX_VAL(PREFIX_VAL)
   ) field_i (
      .data_i(in_byte), .code_o(code), .ok_o(fmt_ok)
   );

   esc_code_map #(
      .BYTE_W(BYTE_W), .CODE_W(CODE_W), .NLIT(NLIT), .LIT_BYTES(LIT_BYTES)
   ) map_i (
      .code_i(code), .sym_o(map_sym)
   );

   esc_out_stage #(.SYM_W(SYM_W)) out_i (
      .clk(clk), .rst_n(rst_n), .load_i(load), .sym_i(sym_n),
      .hold_i(out_hold), .valid_o(out_valid), .sym_o(out_sym),
      .stall_o(stall)
   );

   assign in_busy     = stall;
   assign accept      = in_en & ~stall;
   assign esc_pending = (state_q == DS_AFTER_ESC);

   always_comb begin
      state_n = state_q;
      load    = 1'b0;
      sym_n   = '0;
      bad_n   = 1'b0;
      if (accept) begin
         unique case (state_q)
            DS_PLAIN: begin
               if (in_byte == ESC_BYTE) begin
                  state_n = DS_AFTER_ESC;
               end else begin
                  load  = 1'b1;
                  sym_n = {1'b0, in_byte};
               end
            end
            DS_AFTER_ESC: begin
               state_n = DS_PLAIN;
               if (fmt_ok) begin
                  load  = 1'b1;
                  sym_n = map_sym;
               end else begin
                  bad_n = 1'b1;
               end
            end
            default: state_n = DS_PLAIN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= DS_PLAIN;
         err_pulse <= 1'b0;
      end else begin
         state_q   <= state_n;
         err_pulse <= bad_n;
      end
   end

endmodule

// File: rtl/esc_comma_decoder_chk.sv
module esc_comma_decoder_chk #(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned CODE_W   = 3,
   parameter logic [7:0]  ESC_BYTE = 8'h1B
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    in_byte,
   input logic          in_en,
   input logic          in_busy,
   input logic [8:0]    out_sym,
   input logic          out_valid,
   input logic          out_hold,
   input logic          err_pulse,
   input logic          esc_pending
);
   // R9: a stalled symbol stays put
   assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_hold |=> out_valid && $stable(out_sym));

   // R10: bytes offered while busy leave the decoding state alone
   assert_busy_no_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_busy |=> $stable(esc_pending));

   // R5: commas carry zeros above the code
   assert_comma_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sym[8] |-> out_sym[7:CODE_W] == '0);

   // R7: error flag lasts one cycle
   assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);

   // R7: malformed pair yields no symbol and clears the escape
   assert_err_no_sym_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> !out_valid && !esc_pending);

   // R3: escape byte is swallowed
   assert_esc_absorbed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_en && !in_busy && !esc_pending && in_byte == ESC_BYTE
      |=> !out_valid && esc_pending);

   // R2: plain byte passes with bit 8 clear
   assert_plain_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_en && !in_busy && !esc_pending && in_byte != ESC_BYTE
      |=> out_valid && out_sym == {1'b0, $past(in_byte)});

endmodule

bind esc_comma_decoder esc_comma_decoder_chk #(
   .BYTE_W(BYTE_W), .CODE_W(CODE_W), .ESC_BYTE(ESC_BYTE)
) chk_i (
   .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_en(in_en),
   .in_busy(in_busy), .out_sym(out_sym), .out_valid(out_valid),
   .out_hold(out_hold), .err_pulse(err_pulse), .esc_pending(esc_pending)
);

// File: tb/esc_comma_decoder_tb_top.sv
module esc_comma_decoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       in_en = 1'b0;
   logic       in_busy;
   logic [8:0] out_sym;
   logic       out_valid;
   logic       out_hold = 1'b0;
   logic       err_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   int hold_mode  = 0;
   bit hold_force = 0;
   int hcnt       = 0;

   logic [8:0] q_sym [$];
   int         q_req [$];

   esc_comma_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_en(in_en),
      .in_busy(in_busy), .out_sym(out_sym), .out_valid(out_valid),
      .out_hold(out_hold), .err_pulse(err_pulse)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   // hold pattern generator
   always @(negedge clk) begin
      hcnt++;
      if (hold_force)          out_hold = 1'b1;
      else if (hold_mode != 0) out_hold = (hcnt % 3) != 0;
      else                     out_hold = 1'b0;
   end

   // monitor / scoreboard
   logic [8:0] stall_sym;
   bit         stalled = 0;
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (rst_n) begin
            if (stalled)
               check(out_valid && out_sym == stall_sym, "R9 stall stable",
                     int'(out_sym), int'(stall_sym));
            stalled = out_valid && out_hold;
            stall_sym = out_sym;
            if (out_valid && !out_hold) begin
               if (q_sym.size() == 0) begin
                  check(0, "R7 unexpected symbol", int'(out_sym), 0);
               end else begin
                  logic [8:0] e;
                  int r;
                  e = q_sym.pop_front();
                  r = q_req.pop_front();
                  check(out_sym == e, $sformatf("R%0d symbol", r), int'(out_sym), int'(e));
               end
            end
         end
      end
   end

   // drive one byte until accepted; then check the error flag
   task automatic send_byte(input logic [7:0] b, input bit exp_err, input string req);
      bit busy_s;
      @(negedge clk);
      in_byte = b;
      in_en   = 1'b1;
      forever begin
         #3;
         busy_s = in_busy;
         @(posedge clk);
         if (!busy_s) break;
         @(negedge clk);
      end
      #1;
      in_en = 1'b0;
      check(err_pulse == exp_err, req, int'(err_pulse), int'(exp_err));
   endtask

   task automatic send_plain(input logic [7:0] b);
      q_sym.push_back({1'b0, b}); q_req.push_back(2);
      send_byte(b, 0, "R2 no error on plain byte");
   endtask

   function automatic logic [8:0] exp_code(input logic [2:0] c);
      case (c)
         3'd0: return 9'h011;
         3'd1: return 9'h013;
         3'd2: return 9'h000;
         3'd3: return 9'h01B;
         default: return {6'b100000, c};
      endcase
   endfunction

   task automatic send_code(input logic [2:0] c);
      q_sym.push_back(exp_code(c)); q_req.push_back(c[2] ? 5 : 6);
      send_byte(8'h1B, 0, "R3 escape no error");
      send_byte({2'b01, ~c, c}, 0, "R4 well-formed escape data");
   endtask

   task automatic send_bad(input logic [7:0] b, input string req);
      send_byte(8'h1B, 0, "R3 escape no error");
      send_byte(b, 1, req);
   endtask

   task automatic drain();
      hold_mode = 0;
      repeat (8) @(posedge clk);
      @(negedge clk); #3;
      check(q_sym.size() == 0, "R9 all symbols delivered", q_sym.size(), 0);
   endtask

   initial begin
      #(200000 * 10);
      check(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!out_valid && !err_pulse && !in_busy, "R1 in reset",
            {out_valid, err_pulse, in_busy}, 0);
      rst_n = 1'b1;
      @(negedge clk); #3;
      check(!out_valid && !err_pulse && !in_busy, "R1 after reset",
            {out_valid, err_pulse, in_busy}, 0);

      // R2 plain traffic
      send_plain(8'h41); send_plain(8'h00); send_plain(8'hFF); send_plain(8'h11);
      drain();

      // R3 R4 R5 R6 all codes
      for (int c = 0; c < 8; c++) send_code(3'(c));
      drain();

      // R7 malformed then plain
      send_bad(8'h9C, "R7 bad prefix flags error");
      send_plain(8'h42);
      send_bad(8'h5D, "R7 bad complement flags error");
      send_plain(8'h1C);
      // R8 doubled escape
      send_bad(8'h1B, "R8 doubled escape flags error");
      send_plain(8'h43);
      drain();

      // R9 traffic under hold
      hold_mode = 1;
      send_plain(8'h60);
      send_code(3'd4);
      send_code(3'd3);
      send_bad(8'h40, "R7 bad complement under hold");
      send_plain(8'h61);
      send_code(3'd7);
      send_plain(8'h1A);
      drain();

      // R10 enable low ignored
      @(negedge clk);
      in_byte = 8'h1B; in_en = 1'b0;
      repeat (3) @(negedge clk);
      send_plain(8'h52);
      drain();

      // R10 busy ignored
      hold_force = 1;
      send_plain(8'h50);
      @(negedge clk);
      in_byte = 8'h1B; in_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         #3;
         check(in_busy == 1'b1, "R9 busy while held", int'(in_busy), 1);
         @(negedge clk);
      end
      in_en = 1'b0;
      hold_force = 0;
      send_plain(8'h51);
      drain();

      finish_run();
   end

endmodule